// File: doc/BRIEF.md
# Load-Use and Branch Stall Profiler

The block watches the stream of retired instructions from a pipeline and builds timing statistics without taking part in execution. Each report carries the instruction's unit class, up to two source register indices, a destination register, a two-bit reference field and an end-of-group marker. When an instruction reads a register that a load in the previous issue group wrote, the block adds load-use stall cycles. Taken control transfers add a fixed branch penalty. The block also counts how many control transfers were taken and how many were not.

Loads post their destination into a pending mask. At each issue-group boundary, the pending mask moves into the active mask that consumers are checked against, so a load's shadow lasts for exactly one group. Instructions issued as a parallel pair share one boundary, which is taken only on the report flagged as last. All four statistics are saturating counters that software-facing logic elsewhere can sample.

Top module: `stall_profiler`

## Requirements
- R1: After reset, all four counters read zero and no register is marked as recently loaded.
- R2: Unit classes are coded 0 execute, 1 compare, 2 multiply-accumulate, 3 control transfer, 4 load, 5 store. For classes 0 to 3, each source operand whose register is set in the active load mask adds 2 to the load-stall counter, so two matching operands add 4, even when both name the same register.
- R3: A source field is IDX_W+1 bits wide, and a set top bit means no operand (-1 is all ones). Such a field is never checked, even when its low bits name a loaded register.
- R4: A load sets its destination bit in the pending mask. At each group boundary, the pending mask replaces the active mask and is then cleared, so a load stalls only the next group.
- R5: Store and load instructions check no sources and leave all counters unchanged. They still form group boundaries.
- R6: A control transfer with bit 1 of the reference field set adds 2 to the branch-stall counter and 1 to the taken counter. Otherwise it adds 1 to the untaken counter. Bit 0 of the reference field is ignored.
- R7: A boundary happens only on a valid report with last_i high. Both halves of a parallel pair are checked against the mask from before the pair, and a load in the first half stalls the group that follows.
- R8: Every counter saturates at all ones and holds there.
- R9: Cycles with valid_i low change neither the counters nor the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An instruction report is present |
| unit_i | input | 3 | Unit class code |
| src_a_i | input | IDX_W+1 | First source register; top bit set means none |
| src_b_i | input | IDX_W+1 | Second source register; top bit set means none |
| dst_i | input | IDX_W | Destination register |
| ref_i | input | 2 | Reference field; bit 1 is the branch-taken flag |
| last_i | input | 1 | Report ends its issue group |
| load_stall_o | output | CNT_W | Accumulated load-use stall cycles |
| branch_stall_o | output | CNT_W | Accumulated taken-branch penalty cycles |
| taken_o | output | CNT_W | Taken control transfers |
| untaken_o | output | CNT_W | Untaken control transfers |

## Verification
The bench gives both sources the same loaded register and expects 4. A design that merged the two operand hits would report 2 instead. It loads register 15 and then presents the all-ones none code, which catches a decoder that looks only at the low index bits. It places an unrelated instruction, a store or a second load between producer and consumer to confirm that the shadow lasts one group; a sticky mask would add phantom stalls. Parallel pairs, idle gaps and runs long enough to saturate each counter show whether boundaries are tied to last_i and valid_i, and whether counters wrap to small values.

// File: rtl/stall_prof_pkg.sv
package stall_prof_pkg;
  typedef enum logic [2:0] {
    UNIT_EXEC  = 3'd0,
    UNIT_CMP   = 3'd1,
    UNIT_MAC   = 3'd2,
    UNIT_CTI   = 3'd3,
    UNIT_LOAD  = 3'd4,
    UNIT_STORE = 3'd5
  } unit_e;

  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned INC_W   = 3;
  localparam int unsigned STALL_PENALTY = 2;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned INC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W:0] sum;

  assign sum = {1'b0, cnt_o} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_o <= '0;
    else if (sum[CNT_W])  cnt_o <= '1;
    else                  cnt_o <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/hazard_tracker.sv
module hazard_tracker
  import stall_prof_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  unit_e          unit_i,
  input  logic [IDX_W:0] src_i [NUM_SRC],
  input  logic [IDX_W-1:0] dst_i,
  input  logic           last_i,
  output logic [1:0]     hits_o
);
  localparam int unsigned NREG = 1 << IDX_W;

  logic [NREG-1:0] active_q, pending_q, pending_nxt;
  logic [NUM_SRC-1:0] hit;
  logic consumer;

  assign consumer = valid_i && (unit_i == UNIT_EXEC || unit_i == UNIT_CMP ||
                                unit_i == UNIT_MAC  || unit_i == UNIT_CTI);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    // top bit of the index marks an absent operand
    assign hit[s] = consumer && !src_i[s][IDX_W] && active_q[src_i[s][IDX_W-1:0]];
  end

  assign hits_o = {1'b0, hit[0]} + {1'b0, hit[1]};

  always_comb begin
    pending_nxt = pending_q;
    if (valid_i && unit_i == UNIT_LOAD) pending_nxt[dst_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= '0;
      pending_q <= '0;
    end else if (valid_i) begin
      if (last_i) begin
        active_q  <= pending_nxt;
        pending_q <= '0;
      end else begin
        pending_q <= pending_nxt;
      end
    end
  end
endmodule

// File: rtl/stall_profiler.sv
module stall_profiler
  import stall_prof_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       unit_i,
  input  logic [IDX_W:0]   src_a_i,
  input  logic [IDX_W:0]   src_b_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic [1:0]       ref_i,
  input  logic             last_i,
  output logic [CNT_W-1:0] load_stall_o,
  output logic [CNT_W-1:0] branch_stall_o,
  output logic [CNT_W-1:0] taken_o,
  output logic [CNT_W-1:0] untaken_o
);
  localparam int unsigned NCNT = 4;

  unit_e          unit;
  logic [IDX_W:0] src [NUM_SRC];
  logic [1:0]     hits;
  logic           is_cti, taken;
  logic [INC_W-1:0] inc [NCNT];
  logic [CNT_W-1:0] cnt [NCNT];

  assign unit   = unit_e'(unit_i);
  assign src[0] = src_a_i;
  assign src[1] = src_b_i;

  hazard_tracker #(.IDX_W(IDX_W)) u_haz (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .unit_i (unit),
    .src_i  (src),
    .dst_i  (dst_i),
    .last_i (last_i),
    .hits_o (hits)
  );

  assign is_cti = valid_i && unit == UNIT_CTI;
  assign taken  = is_cti && ref_i[1];

  assign inc[0] = INC_W'(hits) * INC_W'(STALL_PENALTY);
  assign inc[1] = taken ? INC_W'(STALL_PENALTY) : '0;
  assign inc[2] = INC_W'(taken);
  assign inc[3] = INC_W'(is_cti && !ref_i[1]);

  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (inc[c]),
      .cnt_o (cnt[c])
    );
  end

  assign load_stall_o   = cnt[0];
  assign branch_stall_o = cnt[1];
  assign taken_o        = cnt[2];
  assign untaken_o      = cnt[3];
endmodule

// File: rtl/stall_prof_checker.sv
module stall_prof_checker #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [2:0]       unit_i,
  input logic [1:0]       ref_i,
  input logic [CNT_W-1:0] load_stall_o,
  input logic [CNT_W-1:0] branch_stall_o,
  input logic [CNT_W-1:0] taken_o,
  input logic [CNT_W-1:0] untaken_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  a_r5_store_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && unit_i == 3'd5) |=> ($stable(load_stall_o) && $stable(branch_stall_o)
                                     && $stable(taken_o) && $stable(untaken_o)));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(load_stall_o) && $stable(branch_stall_o)
                  && $stable(taken_o) && $stable(untaken_o)));

  a_r6_untaken_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && unit_i == 3'd3 && !ref_i[1] && untaken_o != MAXV)
      |=> untaken_o == CNT_W'($past(untaken_o) + 1'b1));

  a_r6_taken_no_untaken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && unit_i == 3'd3 && ref_i[1]) |=> $stable(untaken_o));

  a_r8_load_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_stall_o == MAXV |=> load_stall_o == MAXV);

  a_r8_taken_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o == MAXV |=> taken_o == MAXV);

  a_r2_load_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> load_stall_o >= $past(load_stall_o));
endmodule

bind stall_profiler stall_prof_checker #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .unit_i        (unit_i),
  .ref_i         (ref_i),
  .load_stall_o  (load_stall_o),
  .branch_stall_o(branch_stall_o),
  .taken_o       (taken_o),
  .untaken_o     (untaken_o)
);

// File: tb/stall_profiler_bench.sv
`timescale 1ns/1ps
module stall_profiler_bench;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned IDX_W = 4;
  localparam logic [IDX_W:0] NONE = '1;

  logic clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0, last_i = 1'b0;
  logic [2:0] unit_i = '0;
  logic [IDX_W:0] src_a_i = '1, src_b_i = '1;
  logic [IDX_W-1:0] dst_i = '0;
  logic [1:0] ref_i = '0;
  logic [CNT_W-1:0] load_stall_o, branch_stall_o, taken_o, untaken_o;

  int n_checks = 0, n_fails = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  stall_profiler #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_stall_profiler (.*);

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req, int ls, int bs, int tk, int ut);
    check({req, " load_stall"}, load_stall_o, ls);
    check({req, " branch_stall"}, branch_stall_o, bs);
    check({req, " taken"}, taken_o, tk);
    check({req, " untaken"}, untaken_o, ut);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    valid_i = 0;
    rst_ni = 0;
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic issue(logic [2:0] u, logic [IDX_W:0] a, logic [IDX_W:0] b,
                       logic [IDX_W-1:0] d, logic [1:0] r, logic last);
    unit_i = u; src_a_i = a; src_b_i = b; dst_i = d; ref_i = r; last_i = last;
    valid_i = 1;
    @(posedge clk_i);
    #1 valid_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    check_all("R1", 0, 0, 0, 0);
    issue(3'd0, 5'd0, 5'd15, 4'd0, 2'b00, 1);
    idle(1);
    check("R1 no stale load mask", load_stall_o, 0);
  endtask

  task automatic t_match();
    do_reset();
    issue(3'd4, NONE, NONE, 4'd3, 2'b00, 1);
    issue(3'd0, 5'd3, NONE, 4'd1, 2'b00, 1);
    idle(1);
    check("R2 single match", load_stall_o, 2);
    issue(3'd4, NONE, NONE, 4'd5, 2'b00, 1);
    issue(3'd2, 5'd5, 5'd5, 4'd1, 2'b00, 1);
    idle(1);
    check("R2 double same reg", load_stall_o, 6);
    issue(3'd4, NONE, NONE, 4'd7, 2'b00, 1);
    issue(3'd1, 5'd2, 5'd7, 4'd0, 2'b00, 1);
    idle(1);
    check("R2 compare second operand", load_stall_o, 8);
    issue(3'd4, NONE, NONE, 4'd6, 2'b00, 1);
    issue(3'd3, 5'd6, NONE, 4'd0, 2'b00, 1);
    idle(1);
    check_all("R2 control transfer source", 10, 0, 0, 1);
  endtask

  task automatic t_none();
    do_reset();
    issue(3'd4, NONE, NONE, 4'd15, 2'b00, 1);
    issue(3'd0, NONE, NONE, 4'd1, 2'b00, 1);
    idle(1);
    check("R3 none code not checked", load_stall_o, 0);
  endtask

  task automatic t_one_old();
    do_reset();
    issue(3'd4, NONE, NONE, 4'd4, 2'b00, 1);
    issue(3'd0, 5'd7, NONE, 4'd1, 2'b00, 1);
    issue(3'd0, 5'd4, NONE, 4'd1, 2'b00, 1);
    idle(1);
    check("R4 two instructions later", load_stall_o, 0);
    issue(3'd4, NONE, NONE, 4'd4, 2'b00, 1);
    issue(3'd4, NONE, NONE, 4'd6, 2'b00, 1);
    issue(3'd0, 5'd4, 5'd6, 4'd1, 2'b00, 1);
    idle(1);
    check("R4 mask replaced by next load", load_stall_o, 2);
  endtask

  task automatic t_store();
    do_reset();
    issue(3'd4, NONE, NONE, 4'd1, 2'b00, 1);
    issue(3'd5, 5'd1, 5'd1, 4'd0, 2'b10, 1);
    idle(1);
    check_all("R5 store exempt", 0, 0, 0, 0);
    issue(3'd0, 5'd1, NONE, 4'd2, 2'b00, 1);
    idle(1);
    check("R5 store is a boundary", load_stall_o, 0);
    issue(3'd4, NONE, NONE, 4'd1, 2'b00, 1);
    issue(3'd4, 5'd1, NONE, 4'd2, 2'b00, 1);
    idle(1);
    check("R5 load source not checked", load_stall_o, 0);
  endtask

  task automatic t_branch();
    do_reset();
    for (int i = 0; i < 3; i++) issue(3'd3, NONE, NONE, 4'd0, 2'b10, 1);
    for (int i = 0; i < 2; i++) issue(3'd3, NONE, NONE, 4'd0, 2'b01, 1);
    issue(3'd3, NONE, NONE, 4'd0, 2'b00, 1);
    issue(3'd0, NONE, NONE, 4'd0, 2'b10, 1);
    idle(1);
    check_all("R6 taken and untaken", 0, 6, 3, 3);
  endtask

  task automatic t_pair();
    do_reset();
    issue(3'd4, NONE, NONE, 4'd8, 2'b00, 0);
    issue(3'd0, 5'd8, NONE, 4'd1, 2'b00, 1);
    idle(1);
    check("R7 partner in pair not stalled", load_stall_o, 0);
    issue(3'd0, 5'd8, NONE, 4'd1, 2'b00, 1);
    idle(1);
    check("R7 next group stalled", load_stall_o, 2);
    issue(3'd4, NONE, NONE, 4'd9, 2'b00, 1);
    issue(3'd0, 5'd9, NONE, 4'd1, 2'b00, 0);
    issue(3'd1, 5'd9, NONE, 4'd1, 2'b00, 1);
    idle(1);
    check("R7 both halves see prior mask", load_stall_o, 6);
  endtask

  task automatic t_idle();
    do_reset();
    issue(3'd4, NONE, NONE, 4'd9, 2'b00, 1);
    idle(5);
    check_all("R9 idle no change", 0, 0, 0, 0);
    issue(3'd0, 5'd9, NONE, 4'd1, 2'b00, 1);
    idle(1);
    check("R9 mask survives idle", load_stall_o, 2);
  endtask

  task automatic t_sat();
    do_reset();
    for (int i = 0; i < 70; i++) begin
      issue(3'd4, NONE, NONE, 4'd0, 2'b00, 1);
      issue(3'd0, 5'd0, 5'd0, 4'd2, 2'b00, 1);
    end
    idle(1);
    check("R8 load stall saturates", load_stall_o, 255);
    for (int i = 0; i < 300; i++) issue(3'd3, NONE, NONE, 4'd0, 2'b10, 1);
    for (int i = 0; i < 260; i++) issue(3'd3, NONE, NONE, 4'd0, 2'b00, 1);
    idle(1);
    check_all("R8 all saturate", 255, 255, 255, 255);
  endtask

  initial begin
    t_reset();
    t_match();
    t_none();
    t_one_old();
    t_store();
    t_branch();
    t_pair();
    t_idle();
    t_sat();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule